// File: doc/BRIEF.md
# Host Memory-Bus Read-Out Bridge with Event Interrupt

This block lets a host processor reach acquired data as if it were an external asynchronous static memory. The host drives an active-low chip select, output enable and write enable, a 16-bit address and a 16-bit data bus. Inside, a 16-bit-wide FIFO is filled from a local streaming port. Each host read of the data address takes one word out of the FIFO. Host writes to two register addresses load an event threshold and acknowledge the interrupt.

The host strobes are never used as clocks. Each strobe is first qualified by chip select, because the bus is shared with other devices. It is then sampled into the system clock through a synchronizer, together with the address and write data. The access takes effect once, on the cycle after its end is detected, however long the host held it. The streaming port marks the last word of each event. Completed events are counted, and the interrupt rises when the count reaches the programmed threshold.

The FIFO depth is a parameter. A setting of 14 address bits gives 16K words, which is 32 KB.

Top module: `hostbus_fifo_bridge`

## Requirements
- R1: After reset the interrupt is low and the read driver is off. The FIFO is empty, both sticky flags are clear, the last-word register holds 0, and the threshold equals the DEF_THRESH parameter.
- R2: The read driver `bus_rdata_en` is high only while `bus_cs_n` and `bus_oe_n` are both low. While it is high, `bus_rdata` shows the FIFO head at address A_FIFO, the status word at A_STAT, and 0 at any other address.
- R3: Activity on `bus_oe_n` or `bus_we_n` while `bus_cs_n` is high is ignored. Nothing is popped, no register is written and the driver stays off.
- R4: Each qualified host access that lasts at least two system clocks produces exactly one action, whatever its length. The action is taken after the access ends, so the word shown during a read stays stable throughout that read.
- R5: Words pushed on the streaming port (`fe_valid` high) are read back at A_FIFO in the order they were pushed.
- R6: The status word at A_STAT uses these bits: bit 0 is sticky underflow, bit 1 is sticky overflow, bit 2 is FIFO empty, bit 3 is FIFO full, and bit 4 is the interrupt state. Bits 15:5 read as 0.
- R7: A push while the FIFO is full drops the word, leaves the contents unchanged, and sets the overflow flag. The flag stays set until reset.
- R8: A read at A_FIFO while the FIFO is empty returns the last word that was popped (0 if none) and sets the underflow flag. The flag stays set until reset.
- R9: Each push with `fe_last` high counts one event. `irq` is high while the threshold is nonzero and the event count is at least the threshold.
- R10: A host write to A_ACK clears the event count, so `irq` falls.
- R11: A host write to A_THR loads the threshold from `bus_wdata`. A threshold of 0 holds `irq` low.
- R12: A read at A_STAT does not pop the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_oe_n | input | 1 | Host output enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_addr | input | 16 | Host address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data toward the host |
| bus_rdata_en | output | 1 | High when the bridge should drive the data bus |
| fe_valid | input | 1 | Streaming word valid, pushes one word |
| fe_last | input | 1 | Marks the last word of an event |
| fe_data | input | 16 | Streaming word |
| irq | output | 1 | Event-threshold interrupt, active high |

## Verification
The bench builds the bridge with 3 address bits, which gives an 8-word FIFO. With that depth, both the full and the empty boundary, and the overflow and underflow flags, are reached with a handful of pushes and reads. DEF_THRESH is set to 2, so the reset threshold is tested by the second event. SYNC_STAGES stays at 2, and host accesses range from 3 to 12 clocks to show that one action is taken per access regardless of its length.

// File: rtl/hfb_pkg.sv
package hfb_pkg;

  localparam int BUS_W = 16;

  typedef logic [BUS_W-1:0] word_t;

  typedef struct packed {
    logic  rd;
    logic  wr;
    word_t addr;
    word_t data;
  } bus_sample_t;

  // strobe qualification: chip select gates every access
  function automatic logic f_rd_qual(input logic cs_n, input logic oe_n);
    return !cs_n && !oe_n;
  endfunction

  function automatic logic f_wr_qual(input logic cs_n, input logic we_n);
    return !cs_n && !we_n;
  endfunction

  function automatic logic f_irq(input word_t count, input word_t thresh);
    return (thresh != '0) && (count >= thresh);
  endfunction

  function automatic word_t f_status(input logic unf, input logic ovf,
                                     input logic empty, input logic full,
                                     input logic irq);
    word_t s;
    s = '0;
    s[0] = unf;
    s[1] = ovf;
    s[2] = empty;
    s[3] = full;
    s[4] = irq;
    return s;
  endfunction

  function automatic word_t f_count_next(input word_t cnt, input logic evt,
                                         input logic clr);
    word_t base;
    base = clr ? '0 : cnt;
    if (evt && base != '1) return base + 1'b1;
    return base;
  endfunction

endpackage

// File: rtl/hfb_bus_sync.sv
module hfb_bus_sync
  import hfb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n,
  input  logic  oe_n,
  input  logic  we_n,
  input  word_t addr,
  input  word_t wdata,
  output logic  rd_done,
  output logic  wr_done,
  output word_t done_addr,
  output word_t done_data
);

  localparam int NSTG = SYNC_STAGES + 1;

  bus_sample_t raw;
  bus_sample_t stg [NSTG];

  always_comb begin
    raw.rd   = f_rd_qual(cs_n, oe_n);
    raw.wr   = f_wr_qual(cs_n, we_n);
    raw.addr = addr;
    raw.data = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTG; i++) stg[i] <= '0;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < NSTG; i++) stg[i] <= stg[i-1];
    end
  end

  // end-of-access detect: oldest stage still active, newer one released
  assign rd_done   = stg[NSTG-1].rd && !stg[NSTG-2].rd;
  assign wr_done   = stg[NSTG-1].wr && !stg[NSTG-2].wr;
  assign done_addr = stg[NSTG-1].addr;
  assign done_data = stg[NSTG-1].data;

endmodule

// File: rtl/hfb_fifo.sv
module hfb_fifo
  import hfb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  word_t       push_data,
  input  logic        pop,
  output word_t       head,
  output logic        empty,
  output logic        full,
  output logic [AW:0] level,
  output logic        ovf,
  output logic        unf
);

  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  word_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   lvl_q;
  word_t         last_q;
  logic          ovf_q, unf_q;
  logic          push_ok, pop_ok;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == DEPTH_L);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lvl_q  <= '0;
      last_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok) begin
        rd_ptr <= rd_ptr + 1'b1;
        last_q <= mem[rd_ptr];
      end
      lvl_q <= lvl_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
      if (push && full) ovf_q <= 1'b1;
      if (pop && empty) unf_q <= 1'b1;
    end
  end

  assign head  = empty ? last_q : mem[rd_ptr];
  assign level = lvl_q;
  assign ovf   = ovf_q;
  assign unf   = unf_q;

endmodule

// File: rtl/hfb_evt_irq.sv
module hfb_evt_irq
  import hfb_pkg::*;
#(
  parameter word_t DEF_THRESH = 16'd1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  evt,
  input  logic  ack,
  input  logic  thr_we,
  input  word_t thr_data,
  output word_t count,
  output word_t thresh,
  output logic  irq
);

  word_t cnt_q, thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      thr_q <= DEF_THRESH;
    end else begin
      cnt_q <= f_count_next(cnt_q, evt, ack);
      if (thr_we) thr_q <= thr_data;
    end
  end

  assign count  = cnt_q;
  assign thresh = thr_q;
  assign irq    = f_irq(cnt_q, thr_q);

endmodule

// File: rtl/hostbus_fifo_bridge.sv
module hostbus_fifo_bridge
  import hfb_pkg::*;
#(
  parameter int          AW          = 10,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] DEF_THRESH  = 16'd1,
  parameter logic [15:0] A_FIFO      = 16'h0000,
  parameter logic [15:0] A_STAT      = 16'h0002,
  parameter logic [15:0] A_THR       = 16'h0004,
  parameter logic [15:0] A_ACK       = 16'h0006
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs_n,
  input  logic        bus_oe_n,
  input  logic        bus_we_n,
  input  logic [15:0] bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_rdata_en,
  input  logic        fe_valid,
  input  logic        fe_last,
  input  logic [15:0] fe_data,
  output logic        irq
);

  // named internal events, observed by the bound checker
  logic        rd_done, wr_done;
  word_t       done_addr, done_data;
  logic        pop_pulse, ack_pulse, thr_pulse;
  word_t       fifo_head;
  logic        fifo_empty, fifo_full, fifo_ovf, fifo_unf;
  logic [AW:0] fifo_level;
  word_t       evt_count, evt_thresh;
  logic        irq_int;

  hfb_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (bus_cs_n),
    .oe_n      (bus_oe_n),
    .we_n      (bus_we_n),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rd_done   (rd_done),
    .wr_done   (wr_done),
    .done_addr (done_addr),
    .done_data (done_data)
  );

  assign pop_pulse = rd_done && (done_addr == A_FIFO);
  assign ack_pulse = wr_done && (done_addr == A_ACK);
  assign thr_pulse = wr_done && (done_addr == A_THR);

  hfb_fifo #(.AW(AW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fe_valid),
    .push_data (fe_data),
    .pop       (pop_pulse),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .level     (fifo_level),
    .ovf       (fifo_ovf),
    .unf       (fifo_unf)
  );

  hfb_evt_irq #(.DEF_THRESH(DEF_THRESH)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (fe_valid && fe_last),
    .ack      (ack_pulse),
    .thr_we   (thr_pulse),
    .thr_data (done_data),
    .count    (evt_count),
    .thresh   (evt_thresh),
    .irq      (irq_int)
  );

  assign irq          = irq_int;
  assign bus_rdata_en = f_rd_qual(bus_cs_n, bus_oe_n);

  always_comb begin
    if (bus_addr == A_FIFO)
      bus_rdata = fifo_head;
    else if (bus_addr == A_STAT)
      bus_rdata = f_status(fifo_unf, fifo_ovf, fifo_empty, fifo_full, irq_int);
    else
      bus_rdata = '0;
  end

endmodule

// File: rtl/hfb_checker.sv
module hfb_checker #(
  parameter int AW = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fe_valid,
  input logic        pop_pulse,
  input logic        wr_done,
  input logic        ack_pulse,
  input logic        fifo_empty,
  input logic        fifo_full,
  input logic        fifo_ovf,
  input logic        fifo_unf,
  input logic [AW:0] fifo_level,
  input logic [15:0] evt_count
);

  localparam logic [AW:0] DEPTH_L = (AW+1)'(1 << AW);

  a_r4_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop_pulse |=> !pop_pulse);

  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);

  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && fe_valid && !pop_pulse) |=> (fifo_full && fifo_ovf));

  a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_unf |=> fifo_unf);

  a_r8_empty_pop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_pulse && fifo_empty && !fe_valid) |=> (fifo_unf && fifo_empty));

  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= DEPTH_L);

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |=> (evt_count <= 16'd1));

endmodule

bind hostbus_fifo_bridge hfb_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fe_valid   (fe_valid),
  .pop_pulse  (pop_pulse),
  .wr_done    (wr_done),
  .ack_pulse  (ack_pulse),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .fifo_ovf   (fifo_ovf),
  .fifo_unf   (fifo_unf),
  .fifo_level (fifo_level),
  .evt_count  (evt_count)
);

// File: tb/hostbus_fifo_bridge_tb_top.sv
`timescale 1ns/1ps
module hostbus_fifo_bridge_tb_top;

  localparam int          AW     = 3;
  localparam int          DEPTH  = 1 << AW;
  localparam logic [15:0] A_FIFO = 16'h0000;
  localparam logic [15:0] A_STAT = 16'h0002;
  localparam logic [15:0] A_THR  = 16'h0004;
  localparam logic [15:0] A_ACK  = 16'h0006;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rdata_en;
  logic        fe_valid = 1'b0, fe_last = 1'b0;
  logic [15:0] fe_data = '0;
  logic        irq;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  logic [15:0] m_q[$];
  logic [15:0] m_last = '0;
  bit          m_ovf = 0, m_unf = 0;
  int          m_cnt = 0;
  int          m_thr = 2;

  always #2.5 clk = ~clk;

  hostbus_fifo_bridge #(
    .AW(AW), .SYNC_STAGES(2), .DEF_THRESH(16'd2),
    .A_FIFO(A_FIFO), .A_STAT(A_STAT), .A_THR(A_THR), .A_ACK(A_ACK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_en(bus_rdata_en),
    .fe_valid(fe_valid), .fe_last(fe_last), .fe_data(fe_data),
    .irq(irq)
  );

  function automatic bit m_irq();
    return (m_thr != 0) && (m_cnt >= m_thr);
  endfunction

  function automatic logic [15:0] m_status();
    logic [15:0] s;
    s = '0;
    s[0] = m_unf;
    s[1] = m_ovf;
    s[2] = (m_q.size() == 0);
    s[3] = (m_q.size() == DEPTH);
    s[4] = m_irq();
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_irq(input string req);
    chk(irq == m_irq(), req, int'(irq), int'(m_irq()));
  endtask

  task automatic fe_push(input logic [15:0] d, input bit last);
    @(negedge clk);
    fe_valid = 1'b1; fe_data = d; fe_last = last;
    @(negedge clk);
    fe_valid = 1'b0; fe_last = 1'b0;
    if (m_q.size() < DEPTH) m_q.push_back(d); else m_ovf = 1;
    if (last) m_cnt++;
  endtask

  task automatic host_read(input logic [15:0] a, input int len, input string req);
    logic [15:0] exp;
    @(negedge clk);
    bus_addr = a; bus_cs_n = 1'b0; bus_oe_n = 1'b0;
    if (a == A_FIFO) exp = (m_q.size() != 0) ? m_q[0] : m_last;
    else if (a == A_STAT) exp = m_status();
    else exp = '0;
    repeat (len) @(negedge clk);
    chk(bus_rdata_en == 1'b1, "R2", int'(bus_rdata_en), 1);
    chk(bus_rdata == exp, req, int'(bus_rdata), int'(exp));
    bus_cs_n = 1'b1; bus_oe_n = 1'b1;
    #1;
    chk(bus_rdata_en == 1'b0, "R2", int'(bus_rdata_en), 0);
    repeat (4) @(negedge clk);
    if (a == A_FIFO) begin
      if (m_q.size() != 0) m_last = m_q.pop_front();
      else m_unf = 1;
    end
  endtask

  task automatic host_write(input logic [15:0] a, input logic [15:0] d, input int len);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_cs_n = 1'b0; bus_we_n = 1'b0;
    repeat (len) @(negedge clk);
    bus_cs_n = 1'b1; bus_we_n = 1'b1;
    repeat (4) @(negedge clk);
    if (a == A_ACK) m_cnt = 0;
    if (a == A_THR) m_thr = int'(d);
  endtask

  // enables toggle with chip select inactive: must change nothing
  task automatic foreign_access(input logic [15:0] a, input bit is_wr, input int len);
    @(negedge clk);
    bus_addr = a; bus_wdata = 16'h0000; bus_cs_n = 1'b1;
    if (is_wr) bus_we_n = 1'b0; else bus_oe_n = 1'b0;
    repeat (len) @(negedge clk);
    chk(bus_rdata_en == 1'b0, "R3", int'(bus_rdata_en), 0);
    bus_oe_n = 1'b1; bus_we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(irq == 1'b0, "R1", int'(irq), 0);
    chk(bus_rdata_en == 1'b0, "R1", int'(bus_rdata_en), 0);
    host_read(A_STAT, 3, "R1 R6 status after reset");
    // R8: read from empty returns 0 and sets underflow
    host_read(A_FIFO, 3, "R8 empty read");
    host_read(A_STAT, 3, "R8 R6 underflow flag");
    // R5, R9: first event of three words, default threshold 2
    fe_push(16'h1111, 0);
    fe_push(16'h2222, 0);
    fe_push(16'h3333, 1);
    chk_irq("R9 below threshold");
    host_read(A_FIFO, 3, "R5 order 1");
    host_read(A_FIFO, 4, "R5 order 2");
    fe_push(16'h4444, 1);
    chk_irq("R9 threshold reached");
    chk(irq == 1'b1, "R9", int'(irq), 1);
    host_read(A_STAT, 3, "R6 irq bit");
    host_read(A_FIFO, 3, "R12 status read did not pop");
    // R10
    host_write(A_ACK, 16'h0000, 3);
    chk_irq("R10 ack clears");
    chk(irq == 1'b0, "R10", int'(irq), 0);
    // R11
    host_write(A_THR, 16'h0001, 3);
    chk_irq("R11 new threshold, no events");
    fe_push(16'h5555, 1);
    chk_irq("R11 threshold 1 reached");
    host_write(A_THR, 16'h0000, 3);
    chk_irq("R11 zero threshold holds irq low");
    chk(irq == 1'b0, "R11", int'(irq), 0);
    host_write(A_THR, 16'h0001, 5);
    chk_irq("R11 threshold restored");
    // R3: foreign bus activity
    foreign_access(A_FIFO, 0, 4);
    foreign_access(A_ACK, 1, 4);
    chk_irq("R3 ignored ack write");
    chk(irq == 1'b1, "R3", int'(irq), 1);
    host_read(A_FIFO, 3, "R3 ignored read did not pop");
    // R4: long access pops once
    host_read(A_FIFO, 12, "R4 long read");
    host_read(A_FIFO, 3, "R4 R8 single pop then last word");
    // R7: overflow
    host_write(A_ACK, 16'h0000, 3);
    chk_irq("R10 second ack");
    for (int i = 0; i < DEPTH + 2; i++) fe_push(16'h00A0 + 16'(i), 0);
    host_read(A_STAT, 3, "R7 R6 full and overflow");
    for (int i = 0; i < DEPTH; i++) host_read(A_FIFO, 3, "R7 R5 contents kept");
    host_read(A_FIFO, 3, "R8 drained read");
    host_read(A_STAT, 3, "R6 final status");
    host_read(16'h0010, 3, "R2 unmapped address");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule